// File: doc/BRIEF.md
# USB Low-Speed Serial Receiver

This block turns the raw differential line pair of a low-speed USB link into a stream of received bytes. It runs from a clock at eight times the 1.5 Mbit/s bit rate, so each bit lasts eight clocks. Both line inputs pass through a synchronizer. The receiver then waits for a J-to-K transition and checks the line again one and a half bits later. It treats the sync field as complete only when it sees two K bits in a row. From that point it samples once per bit at a fixed phase near the bit centre. It undoes the NRZI coding, drops stuffed bits and builds bytes least significant bit first.

Each completed byte appears for one clock on a byte output with a valid strobe. A single-ended zero (both lines low) ends the packet, unless it falls in the first bit slot of a byte. Hubs can add a dribble bit in that slot. When the packet ends, an end pulse reports how many whole bytes were received. A packet longer than the configured byte limit is cut off with an overflow pulse. A sync search that finds no edge in time raises a sync error pulse.

Top module: `usb_ls_rx`

## Requirements
- R1: The line states are decoded after a two-stage synchronizer. J is line_p=0 with line_m=1. K is line_p=1 with line_m=0. SE0 is both lines low. A start of sync is a synchronized J followed by a synchronized K on the next clock.
- R2: After a J-to-K transition the receiver samples the line OVS+OVS/2 clocks later. If the line is K (the double K), reception starts. If it is J, the receiver waits for the next J-to-K transition. No bytes are produced without a double K.
- R3: While waiting for a further transition, if none comes within SYNC_TO clocks, rx_sync_err pulses for one clock and the receiver returns to idle.
- R4: NRZI decoding: a sampled line level equal to the previous one gives a 1, and a change gives a 0. The level before the first data bit is K, the last sync bit.
- R5: The run of decoded 1s starts at one after sync, because the final double K counts as a 1. After six 1s in a row, the next bit is discarded and is not placed in the byte. The run also carries across byte boundaries.
- R6: Decoded bits fill the byte least significant bit first. Each eighth bit makes rx_byte_vld high for exactly one clock with the byte on rx_byte. This happens less than two bit times after that bit starts on the line.
- R7: An SE0 sampled in bit slot 1 to 7 of a byte ends the packet. rx_end pulses once with rx_count equal to the number of completed bytes, and a partial byte is dropped.
- R8: An SE0 sampled in bit slot 0 does not end the packet. It is decoded from line_m alone, which reads as a K level.
- R9: At most MAX_BYTES bytes are presented per packet. The byte after the last allowed one is not presented. Instead rx_overflow pulses once, no rx_end follows, and the line is ignored until the next SE0.
- R10: After reset all strobes are low and rx_count is zero. At most one of rx_byte_vld, rx_end, rx_overflow and rx_sync_err is high in any clock.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Sample clock, OVS times the bit rate |
| rst_n | input | 1 | Synchronous active-low reset |
| line_p | input | 1 | Raw positive data line |
| line_m | input | 1 | Raw negative data line |
| rx_byte | output | 8 | Received byte, valid with rx_byte_vld |
| rx_byte_vld | output | 1 | One-clock strobe per completed byte |
| rx_end | output | 1 | One-clock pulse at end of packet |
| rx_count | output | $clog2(MAX_BYTES+1) | Completed byte count, updated with rx_end |
| rx_overflow | output | 1 | One-clock pulse when the byte limit is exceeded |
| rx_sync_err | output | 1 | One-clock pulse when the sync search times out |

## Verification
A byte is due about seven clocks after its eighth bit starts on the line: two synchronizer stages, half a bit to the sample point, and one output register. An end pulse is due about seven clocks after the SE0 bit that ends the packet. That is fifteen clocks after the start of the end sequence when the first SE0 falls in slot 0. When the driver starts the last bit of a byte, or the end sequence, it records the current cycle together with the expected value. The monitor samples on the falling edge and requires each result to arrive within a window of half a bit to two bits, or three bits for the end pulse, counted from that recorded cycle. Overflow and sync error pulses are counted and compared once the line has gone back to idle.

// File: rtl/usb_ls_rx_pkg.sv
// Shared types for the low-speed receiver.
// Assumes: bytes are eight bits wide.
package usb_ls_rx_pkg;
    localparam int BYTE_W = 8;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_CONFIRM,
        ST_HUNT,
        ST_RECV,
        ST_DRAIN
    } rx_state_t;
endpackage

// File: rtl/usb_ls_line_front.sv
// Line front end: synchronizes both raw lines and classifies the line state.
// It also flags a J-to-K transition between consecutive clocks.
// Assumes: SYNC_STAGES >= 2, and the lines rest at J during reset.
module usb_ls_line_front #(
    parameter int SYNC_STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic line_p,
    input  logic line_m,
    output logic is_k,
    output logic is_se0,
    output logic m_lvl,
    output logic jk_edge
);
    logic [SYNC_STAGES-1:0] p_ff;
    logic [SYNC_STAGES-1:0] m_ff;
    logic                   was_j;
    logic                   is_j;

    // Synchronizer chains plus a one-clock memory of the J state.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            p_ff  <= '0;
            m_ff  <= '1;
            was_j <= 1'b1;
        end else begin
            p_ff  <= {p_ff[SYNC_STAGES-2:0], line_p};
            m_ff  <= {m_ff[SYNC_STAGES-2:0], line_m};
            was_j <= is_j;
        end
    end

    // Line state decode from the last synchronizer stage.
    always_comb begin
        is_j    = !p_ff[SYNC_STAGES-1] &&  m_ff[SYNC_STAGES-1];
        is_k    =  p_ff[SYNC_STAGES-1] && !m_ff[SYNC_STAGES-1];
        is_se0  = !p_ff[SYNC_STAGES-1] && !m_ff[SYNC_STAGES-1];
        m_lvl   =  m_ff[SYNC_STAGES-1];
        jk_edge =  was_j && is_k;
    end

    AST_EDGE_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
        jk_edge |=> !jk_edge); // R1
endmodule

// File: rtl/usb_ls_rx_ctrl.sv
// Receive sequencer. It locks onto J-to-K transitions in the sync field and
// confirms the double K. It times the sync search, then emits one sampling
// strobe per bit near the bit centre until the packet ends or overflows.
// Assumes: OVS >= 4 and even; pkt_end/pkt_abort arrive one clock after a strobe.
module usb_ls_rx_ctrl
    import usb_ls_rx_pkg::*;
#(
    parameter int OVS     = 8,
    parameter int SYNC_TO = 16
) (
    input  logic clk,
    input  logic rst_n,
    input  logic is_k,
    input  logic is_se0,
    input  logic jk_edge,
    input  logic pkt_end,
    input  logic pkt_abort,
    output logic bit_stb,
    output logic rx_start,
    output logic sync_err
);
    localparam int CONF_AT = OVS + OVS / 2 - 1;
    localparam int PW      = $clog2(CONF_AT + 1);
    localparam int TW      = $clog2(SYNC_TO + 1);
    localparam logic [PW-1:0] PH_CONF = PW'(CONF_AT);
    localparam logic [PW-1:0] PH_LAST = PW'(OVS - 1);
    localparam logic [TW-1:0] TMO_END = TW'(SYNC_TO - 1);

    rx_state_t       state;
    logic [PW-1:0]   ph;
    logic [TW-1:0]   tmo;

    // Strobes decoded from the current state and phase.
    always_comb begin
        bit_stb  = (state == ST_RECV) && (ph == PH_LAST);
        rx_start = (state == ST_CONFIRM) && (ph == PH_CONF) && is_k;
    end

    // State, bit phase and sync timeout sequencing.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state    <= ST_IDLE;
            ph       <= '0;
            tmo      <= '0;
            sync_err <= 1'b0;
        end else begin
            sync_err <= 1'b0;
            case (state)
                ST_IDLE: begin
                    if (jk_edge) begin
                        state <= ST_CONFIRM;
                        ph    <= '0;
                    end
                end
                ST_CONFIRM: begin
                    if (ph == PH_CONF) begin
                        ph  <= '0;
                        tmo <= '0;
                        state <= is_k ? ST_RECV : ST_HUNT;
                    end else begin
                        ph <= ph + 1'b1;
                    end
                end
                ST_HUNT: begin
                    if (jk_edge) begin
                        state <= ST_CONFIRM;
                        ph    <= '0;
                    end else if (tmo == TMO_END) begin
                        state    <= ST_IDLE;
                        sync_err <= 1'b1;
                    end else begin
                        tmo <= tmo + 1'b1;
                    end
                end
                ST_RECV: begin
                    if (pkt_abort) begin
                        state <= ST_DRAIN;
                    end else if (pkt_end) begin
                        state <= ST_IDLE;
                    end else begin
                        ph <= (ph == PH_LAST) ? '0 : ph + 1'b1;
                    end
                end
                ST_DRAIN: begin
                    if (is_se0) state <= ST_IDLE;
                end
                default: state <= ST_IDLE;
            endcase
        end
    end

    AST_SYNC_ERR_TO_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        sync_err |-> state == ST_IDLE); // R3
    AST_STB_SPACED: assert property (@(posedge clk) disable iff (!rst_n)
        bit_stb |=> !bit_stb); // R6
    AST_START_ENTERS_RECV: assert property (@(posedge clk) disable iff (!rst_n)
        rx_start |=> state == ST_RECV); // R2
endmodule

// File: rtl/usb_ls_rx_deser.sv
// Bit decoder and byte assembler. On each sampling strobe it checks for an
// end of packet, undoes NRZI, drops stuffed bits, shifts data in LSB first
// and enforces the per-packet byte limit.
// Assumes: rx_start and bit_stb are never high together.
module usb_ls_rx_deser
    import usb_ls_rx_pkg::*;
#(
    parameter int MAX_BYTES = 11,
    parameter int STUFF_RUN = 6
) (
    input  logic                           clk,
    input  logic                           rst_n,
    input  logic                           rx_start,
    input  logic                           bit_stb,
    input  logic                           m_lvl,
    input  logic                           is_se0,
    output logic [BYTE_W-1:0]              byte_data,
    output logic                           byte_valid,
    output logic                           pkt_done,
    output logic [$clog2(MAX_BYTES+1)-1:0] pkt_len,
    output logic                           err_ovf
);
    localparam int CW  = $clog2(MAX_BYTES + 1);
    localparam int PBW = $clog2(BYTE_W);
    localparam int OW  = $clog2(STUFF_RUN + 1);
    localparam logic [PBW-1:0] POS_LAST = PBW'(BYTE_W - 1);
    localparam logic [CW-1:0]  CNT_MAX  = CW'(MAX_BYTES);
    localparam logic [OW-1:0]  RUN_MAX  = OW'(STUFF_RUN);

    logic              prev_lvl;
    logic [OW-1:0]     ones;
    logic [BYTE_W-1:0] sh;
    logic [PBW-1:0]    pos;
    logic [CW-1:0]     cnt;
    logic              bit_val;
    logic [BYTE_W-1:0] sh_next;
    logic              last_slot;

    // NRZI decode and next shift value for the current sample.
    always_comb begin
        bit_val   = (m_lvl == prev_lvl);
        sh_next   = {bit_val, sh[BYTE_W-1:1]};
        last_slot = (pos == POS_LAST);
    end

    // Per-bit decode, unstuffing, byte completion and packet end handling.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            prev_lvl   <= 1'b0;
            ones       <= '0;
            sh         <= '0;
            pos        <= '0;
            cnt        <= '0;
            byte_data  <= '0;
            byte_valid <= 1'b0;
            pkt_done   <= 1'b0;
            pkt_len    <= '0;
            err_ovf    <= 1'b0;
        end else begin
            byte_valid <= 1'b0;
            pkt_done   <= 1'b0;
            err_ovf    <= 1'b0;
            if (rx_start) begin
                prev_lvl <= 1'b0;
                ones     <= OW'(1);
                sh       <= '0;
                pos      <= '0;
                cnt      <= '0;
            end else if (bit_stb) begin
                if (is_se0 && (pos != '0)) begin
                    pkt_done <= 1'b1;
                    pkt_len  <= cnt;
                end else begin
                    prev_lvl <= m_lvl;
                    if (ones == RUN_MAX) begin
                        ones <= '0;
                    end else begin
                        ones <= bit_val ? ones + 1'b1 : '0;
                        sh   <= sh_next;
                        pos  <= last_slot ? '0 : pos + 1'b1;
                        if (last_slot) begin
                            if (cnt == CNT_MAX) begin
                                err_ovf <= 1'b1;
                            end else begin
                                byte_valid <= 1'b1;
                                byte_data  <= sh_next;
                                cnt        <= cnt + 1'b1;
                            end
                        end
                    end
                end
            end
        end
    end

    AST_RUN_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
        ones <= RUN_MAX); // R5
    AST_COUNT_LIMIT: assert property (@(posedge clk) disable iff (!rst_n)
        byte_valid |-> cnt <= CNT_MAX); // R9
    AST_END_ALONE: assert property (@(posedge clk) disable iff (!rst_n)
        pkt_done |-> !err_ovf && !byte_valid); // R7
endmodule

// File: rtl/usb_ls_rx.sv
// Low-speed USB receiver top: line front end, receive sequencer and
// bit decoder wired together. Outputs are registered one-clock pulses.
// Assumes: clk runs at OVS times the line bit rate.
module usb_ls_rx
    import usb_ls_rx_pkg::*;
#(
    parameter int OVS         = 8,
    parameter int MAX_BYTES   = 11,
    parameter int SYNC_TO     = 16,
    parameter int SYNC_STAGES = 2,
    parameter int STUFF_RUN   = 6
) (
    input  logic                           clk,
    input  logic                           rst_n,
    input  logic                           line_p,
    input  logic                           line_m,
    output logic [7:0]                     rx_byte,
    output logic                           rx_byte_vld,
    output logic                           rx_end,
    output logic [$clog2(MAX_BYTES+1)-1:0] rx_count,
    output logic                           rx_overflow,
    output logic                           rx_sync_err
);
    logic is_k;
    logic is_se0;
    logic m_lvl;
    logic jk_edge;
    logic bit_stb;
    logic rx_start;

    usb_ls_line_front #(.SYNC_STAGES(SYNC_STAGES)) u_front (
        .clk     (clk),
        .rst_n   (rst_n),
        .line_p  (line_p),
        .line_m  (line_m),
        .is_k    (is_k),
        .is_se0  (is_se0),
        .m_lvl   (m_lvl),
        .jk_edge (jk_edge)
    );

    usb_ls_rx_ctrl #(.OVS(OVS), .SYNC_TO(SYNC_TO)) u_ctrl (
        .clk       (clk),
        .rst_n     (rst_n),
        .is_k      (is_k),
        .is_se0    (is_se0),
        .jk_edge   (jk_edge),
        .pkt_end   (rx_end),
        .pkt_abort (rx_overflow),
        .bit_stb   (bit_stb),
        .rx_start  (rx_start),
        .sync_err  (rx_sync_err)
    );

    usb_ls_rx_deser #(.MAX_BYTES(MAX_BYTES), .STUFF_RUN(STUFF_RUN)) u_deser (
        .clk        (clk),
        .rst_n      (rst_n),
        .rx_start   (rx_start),
        .bit_stb    (bit_stb),
        .m_lvl      (m_lvl),
        .is_se0     (is_se0),
        .byte_data  (rx_byte),
        .byte_valid (rx_byte_vld),
        .pkt_done   (rx_end),
        .pkt_len    (rx_count),
        .err_ovf    (rx_overflow)
    );

    AST_ONE_EVENT: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({rx_byte_vld, rx_end, rx_overflow, rx_sync_err})); // R10
endmodule

// File: tb/sim_usb_ls_rx.sv
// Scoreboard bench: driver tasks encode packets onto the line and queue the
// expected bytes and end events; a falling-edge monitor pops and compares.
module sim_usb_ls_rx;
    localparam int OVS  = 8;
    localparam int MAXB = 11;
    localparam int STO  = 16;
    localparam int CW   = $clog2(MAXB + 1);
    localparam int LV_J = 0;
    localparam int LV_K = 1;
    localparam int LV_Z = 2;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          line_p = 1'b0;
    logic          line_m = 1'b1;
    logic [7:0]    rx_byte;
    logic          rx_byte_vld;
    logic          rx_end;
    logic [CW-1:0] rx_count;
    logic          rx_overflow;
    logic          rx_sync_err;

    usb_ls_rx #(.OVS(OVS), .MAX_BYTES(MAXB), .SYNC_TO(STO)) u0 (
        .clk(clk), .rst_n(rst_n), .line_p(line_p), .line_m(line_m),
        .rx_byte(rx_byte), .rx_byte_vld(rx_byte_vld), .rx_end(rx_end),
        .rx_count(rx_count), .rx_overflow(rx_overflow), .rx_sync_err(rx_sync_err)
    );

    always #4 clk = ~clk;

    int cyc = 0;
    always @(posedge clk) cyc <= cyc + 1;

    int    n_chk = 0;
    int    n_fail = 0;
    int    q_byte[$];
    int    q_byte_t[$];
    int    q_end[$];
    int    q_end_t[$];
    int    n_ovf = 0;
    int    n_serr = 0;
    int    n_bytes = 0;
    int    cur_lvl = LV_J;
    int    ones_run = 0;
    string cur_req = "R6";
    bit    finished = 1'b0;

    task automatic check_eq(string req, string what, int act, int exp);
        n_chk++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
        end
    endtask

    task automatic drive(int lv);
        @(negedge clk);
        line_p = (lv == LV_K);
        line_m = (lv == LV_J);
        repeat (OVS - 1) @(negedge clk);
    endtask

    function automatic int flip(int lv);
        return (lv == LV_J) ? LV_K : LV_J;
    endfunction

    task automatic tx_bit(bit b, bit se0_sub, bit push, int val);
        if (ones_run == 6) begin
            cur_lvl = flip(cur_lvl);
            drive(cur_lvl);
            ones_run = 0;
        end
        if (!b) cur_lvl = flip(cur_lvl);
        if (push) begin
            q_byte.push_back(val);
            q_byte_t.push_back(cyc);
        end
        drive((se0_sub && cur_lvl == LV_K) ? LV_Z : cur_lvl);
        ones_run = b ? ones_run + 1 : 0;
    endtask

    task automatic tx_byte(logic [7:0] v, bit se0_first, bit expect_out);
        for (int i = 0; i < 8; i++) tx_bit(v[i], se0_first && (i == 0), expect_out && (i == 7), int'(v));
    endtask

    task automatic tx_sync();
        drive(LV_K); drive(LV_J); drive(LV_K); drive(LV_J);
        drive(LV_K); drive(LV_J); drive(LV_K); drive(LV_K);
        cur_lvl = LV_K;
        ones_run = 1;
    endtask

    task automatic tx_eop(bit expect_end, int len);
        if (ones_run == 6) begin
            cur_lvl = flip(cur_lvl);
            drive(cur_lvl);
            ones_run = 0;
        end
        if (expect_end) begin
            q_end.push_back(len);
            q_end_t.push_back(cyc);
        end
        drive(LV_Z); drive(LV_Z);
        repeat (4) drive(LV_J);
        cur_lvl = LV_J;
    endtask

    // Monitor: compare every produced result against the scoreboard queues.
    always @(negedge clk) begin
        if (rst_n && !finished) begin
            if (rx_byte_vld) begin
                n_bytes++;
                if (q_byte.size() == 0) begin
                    check_eq(cur_req, "unexpected byte", int'(rx_byte), -1);
                end else begin
                    int e;
                    int t;
                    e = q_byte.pop_front();
                    t = q_byte_t.pop_front();
                    check_eq(cur_req, "byte value", int'(rx_byte), e);
                    check_eq("R6", "byte due window", int'((cyc - t) >= OVS/2 && (cyc - t) <= 2*OVS), 1);
                end
            end
            if (rx_end) begin
                if (q_end.size() == 0) begin
                    check_eq(cur_req, "unexpected end", int'(rx_count), -1);
                end else begin
                    int e;
                    int t;
                    e = q_end.pop_front();
                    t = q_end_t.pop_front();
                    check_eq("R7", "end byte count", int'(rx_count), e);
                    check_eq("R7", "end due window", int'((cyc - t) >= OVS/2 && (cyc - t) <= 3*OVS), 1);
                end
            end
            if (rx_overflow) n_ovf++;
            if (rx_sync_err) n_serr++;
        end
    end

    task automatic finish_run();
        finished = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    endtask

    // Watchdog: a hung run is a failed check.
    initial begin
        repeat (200000) @(posedge clk);
        if (!finished) begin
            n_chk++;
            n_fail++;
            $display("FAIL R10 watchdog: actual %0d cycles expected completion", cyc);
            finish_run();
        end
    end

    initial begin
        int base;
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R10: reset state
        check_eq("R10", "byte strobe after reset", int'(rx_byte_vld), 0);
        check_eq("R10", "end after reset", int'(rx_end), 0);
        check_eq("R10", "count after reset", int'(rx_count), 0);
        check_eq("R10", "overflow after reset", int'(rx_overflow), 0);
        check_eq("R10", "sync error after reset", int'(rx_sync_err), 0);
        repeat (3) drive(LV_J);

        // R4: NRZI patterns with runs and alternations
        cur_req = "R4";
        base = n_bytes;
        tx_sync();
        tx_byte(8'h80, 0, 1); tx_byte(8'h3C, 0, 1); tx_byte(8'hA5, 0, 1); tx_byte(8'h00, 0, 1);
        tx_eop(1, 4);
        check_eq("R1", "bytes from synchronized line", n_bytes - base, 4);

        // R5: stuffed bits across and inside bytes
        cur_req = "R5";
        tx_sync();
        tx_byte(8'hFF, 0, 1); tx_byte(8'hFF, 0, 1); tx_byte(8'h7E, 0, 1); tx_byte(8'h3F, 0, 1);
        tx_eop(1, 4);

        // R8: SE0 in slot 0 of the second byte is read as K
        cur_req = "R8";
        tx_sync();
        tx_byte(8'h80, 0, 1); tx_byte(8'h3C, 1, 1); tx_byte(8'h5A, 0, 1);
        tx_eop(1, 3);

        // R7: SE0 mid-byte ends the packet and drops the partial byte
        cur_req = "R7";
        tx_sync();
        tx_byte(8'h12, 0, 1);
        tx_bit(1'b1, 0, 0, 0); tx_bit(1'b0, 0, 0, 0); tx_bit(1'b1, 0, 0, 0);
        tx_eop(1, 1);

        // R9: one byte beyond the limit aborts without an end pulse
        cur_req = "R9";
        base = n_ovf;
        tx_sync();
        for (int i = 0; i <= MAXB; i++) tx_byte(8'(8'h11 * (i + 1)), 0, i < MAXB);
        tx_eop(0, 0);
        check_eq("R9", "overflow pulses", n_ovf - base, 1);

        // R9: receiver recovers for the next packet
        tx_sync();
        tx_byte(8'hC3, 0, 1);
        tx_eop(1, 1);

        // R3 and R2: single K, then K/J alternation without a double K
        cur_req = "R2";
        base = n_bytes;
        drive(LV_K);
        repeat (6) drive(LV_J);
        check_eq("R3", "sync timeout after single K", n_serr, 1);
        drive(LV_K); drive(LV_J); drive(LV_K); drive(LV_J); drive(LV_K); drive(LV_J);
        repeat (6) drive(LV_J);
        check_eq("R3", "sync timeout after alternation", n_serr, 2);
        check_eq("R2", "no bytes without double K", n_bytes - base, 0);

        // R6 / R7: everything queued has arrived
        repeat (4) drive(LV_J);
        check_eq("R6", "bytes still pending", q_byte.size(), 0);
        check_eq("R7", "ends still pending", q_end.size(), 0);
        check_eq("R9", "total overflow pulses", n_ovf, 1);
        finish_run();
    end
endmodule